// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block compares two pulse trains inside a synthesizer loop: the divided oscillator pulse and the divided reference pulse. Each rising edge is sampled on a fast clock. The block produces a pump-up pulse when the reference edge comes first and a pump-down pulse when the oscillator edge comes first. Each pulse lasts from the leading edge until the lagging edge arrives, so its width in clock cycles follows the phase error.

The detector has three states. After the lagging edge, both pulses are high together for exactly one clock cycle, and then both clear. This fixed overlap keeps a small correction active even at zero phase error, which avoids a dead zone.

A lock indicator works from an activity signal that is high whenever either pulse is high. A saturating up/down counter integrates this activity. The lock output is raised when the counter sits below a threshold set on a port. It is held low until one full reference period has passed since reset. An output-enable input silences the pump outputs without stopping detection or lock tracking.

Top module: `pfd_lock_detect`

## Requirements
- R1: Only a rising edge starts a pulse. An input held high after its edge does not restart a pulse once the pulse has been cleared.
- R2: A reference edge sampled at clock edge k, followed by an oscillator edge sampled at edge k+d, gives pump_up high for d+1 samples and pump_dn high for 1 sample.
- R3: The same rule holds with the roles swapped. When the oscillator edge leads by d cycles, pump_dn is high for d+1 samples and pump_up for 1 sample.
- R4: When both internal pulses are high, both clear on the next clock. Edges sampled on the same clock give exactly one cycle with both pulses high.
- R5: When out_en is 0, pump_up and pump_dn are forced to 0. Internal detection, nand_act and lock tracking carry on unchanged.
- R6: nand_act is 1 exactly while either internal pulse is active, whatever the value of out_en.
- R7: The integrator resets to 0. On each clock it adds 1 while activity is high and subtracts 1 otherwise, and it saturates at 0 and at 2^CNT_W-1. After saturation at the top with lock_thresh=T, lock_ok rises 65-T samples after the first sample with pump_dn high (CNT_W=6).
- R8: After arming, lock_ok is 1 exactly when the integrator value is below lock_thresh. A threshold of 0 holds lock_ok low.
- R9: lock_ok stays 0 until two reference rising edges have been seen after reset.
- R10: During reset, and at release, pump_up, pump_dn, nand_act and lock_ok are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | Divided reference pulse |
| vco_pulse | input | 1 | Divided oscillator pulse |
| out_en | input | 1 | Pump output enable, active high |
| lock_thresh | input | CNT_W | Integrator level below which lock is reported |
| pump_up | output | 1 | Raise-frequency pulse |
| pump_dn | output | 1 | Lower-frequency pulse |
| nand_act | output | 1 | Combined pulse activity |
| lock_ok | output | 1 | Lock indication |

## Verification
The bench measures pulse widths for leads of several cycles in each direction and for coincident edges. A design without the overlap reset would keep both pulses high, and one with an off-by-one error would report widths of d or d+2.

An input is held high across a cleared pulse. A level-triggered design would raise a second pulse.

The bench drives the integrator into saturation and times the lock rise after release. A counter that wraps would unlock far too early or too late.

The bench also checks lock while only one reference edge has been seen, to catch arming that is early or missing. It checks out_en low, to catch a gate that also stalls the internal state.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef struct packed {
        logic ref_rise;
        logic vco_rise;
    } edge_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    typedef enum logic [1:0] {
        ARM_IDLE  = 2'd0,
        ARM_ONE   = 2'd1,
        ARM_READY = 2'd2
    } arm_e;

    function automatic int unsigned sat_step(input int unsigned cur,
                                             input int unsigned top,
                                             input logic        inc);
        if (inc) return (cur >= top) ? top : cur + 1;
        return (cur == 0) ? 0 : cur - 1;
    endfunction

endpackage

// File: rtl/pfd_edge_rise.sv
module pfd_edge_rise
    import pfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_in,
    input  logic  vco_in,
    output edge_t edges
);
    logic [1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= {ref_in, vco_in};
    end

    assign edges.ref_rise = ref_in & ~prev_q[1];
    assign edges.vco_rise = vco_in & ~prev_q[0];
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  edge_t edges,
    output pump_t pulses
);
    pump_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (state_q.up && state_q.dn) begin
            state_q <= '0;
        end else begin
            state_q.up <= state_q.up | edges.ref_rise;
            state_q.dn <= state_q.dn | edges.vco_rise;
        end
    end

    assign pulses = state_q;

    // R4
    overlap_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q.up && state_q.dn) |=> (!state_q.up && !state_q.dn));

    // R1
    up_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q.up) |-> $past(edges.ref_rise));

    // R1
    dn_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q.dn) |-> $past(edges.vco_rise));
endmodule

// File: rtl/pfd_lock_integ.sv
module pfd_lock_integ
    import pfd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             ref_rise,
    input  logic [CNT_W-1:0] thresh,
    output logic             lock
);
    localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    arm_e             arm_q;

    assign cnt_d = CNT_W'(sat_step(int'(cnt_q), CNT_MAX, active));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            arm_q <= ARM_IDLE;
        end else begin
            cnt_q <= cnt_d;
            if (ref_rise) begin
                case (arm_q)
                    ARM_IDLE: arm_q <= ARM_ONE;
                    ARM_ONE:  arm_q <= ARM_READY;
                    default:  arm_q <= ARM_READY;
                endcase
            end
        end
    end

    assign lock = (arm_q == ARM_READY) && (cnt_q < thresh);

    // R7
    sat_top_chk: assert property (@(posedge clk) disable iff (rst)
        (active && cnt_q == CNT_W'(CNT_MAX)) |=> (cnt_q == CNT_W'(CNT_MAX)));

    // R7
    decay_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R9
    arm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (arm_q == ARM_IDLE) |=> (arm_q != ARM_READY));
endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect
    import pfd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_pulse,
    input  logic             vco_pulse,
    input  logic             out_en,
    input  logic [CNT_W-1:0] lock_thresh,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             nand_act,
    output logic             lock_ok
);
    edge_t edges;
    pump_t pulses;

    pfd_edge_rise u_edge (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_pulse),
        .vco_in (vco_pulse),
        .edges  (edges)
    );

    pfd_core u_core (
        .clk    (clk),
        .rst    (rst),
        .edges  (edges),
        .pulses (pulses)
    );

    assign nand_act = ~(~pulses.up & ~pulses.dn);
    assign pump_up  = pulses.up & out_en;
    assign pump_dn  = pulses.dn & out_en;

    pfd_lock_integ #(.CNT_W(CNT_W)) u_integ (
        .clk      (clk),
        .rst      (rst),
        .active   (nand_act),
        .ref_rise (edges.ref_rise),
        .thresh   (lock_thresh),
        .lock     (lock_ok)
    );

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!nand_act && !lock_ok));
endmodule

// File: tb/pfd_lock_detect_tb.sv
module pfd_lock_detect_tb;
    localparam int CNT_W = 6;
    localparam int TOP   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_pulse = 1'b0;
    logic vco_pulse = 1'b0;
    logic out_en = 1'b1;
    logic [CNT_W-1:0] lock_thresh = 6'd10;
    logic pump_up, pump_dn, nand_act, lock_ok;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pfd_lock_detect #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
        .out_en(out_en), .lock_thresh(lock_thresh),
        .pump_up(pump_up), .pump_dn(pump_dn), .nand_act(nand_act), .lock_ok(lock_ok)
    );

    // behavioural reference
    bit m_up, m_dn, m_pref, m_pvco;
    int m_cnt, m_edges;

    always @(posedge clk) begin
        bit rr, rv, act;
        rr = ref_pulse && !m_pref;
        rv = vco_pulse && !m_pvco;
        if (rst) begin
            m_up = 0; m_dn = 0; m_cnt = 0; m_edges = 0; m_pref = 0; m_pvco = 0;
        end else begin
            act = m_up || m_dn;
            if (m_up && m_dn) begin
                m_up = 0; m_dn = 0;
            end else begin
                m_up = m_up || rr;
                m_dn = m_dn || rv;
            end
            if (act) m_cnt = (m_cnt == TOP) ? TOP : m_cnt + 1;
            else     m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
            if (rr && m_edges < 2) m_edges++;
            m_pref = ref_pulse;
            m_pvco = vco_pulse;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison and pulse measurement
    int cyc = 0, up_run = 0, dn_run = 0, last_up_w = 0, last_dn_w = 0;
    int up_rises = 0, dn_rise_cyc = 0, lock_rise_cyc = 0;
    bit p_up = 0, p_dn = 0, p_lock = 0;

    always begin
        @(posedge clk);
        #2;
        cyc++;
        check("R2", "pump_up", int'(pump_up), int'(m_up && out_en));
        check("R3", "pump_dn", int'(pump_dn), int'(m_dn && out_en));
        check("R6", "nand_act", int'(nand_act), int'(m_up || m_dn));
        check("R8", "lock_ok", int'(lock_ok),
              int'(m_edges == 2 && m_cnt < int'(lock_thresh)));
        if (pump_up) up_run++;
        else if (up_run > 0) begin last_up_w = up_run; up_run = 0; end
        if (pump_dn) dn_run++;
        else if (dn_run > 0) begin last_dn_w = dn_run; dn_run = 0; end
        if (pump_up && !p_up) up_rises++;
        if (pump_dn && !p_dn) dn_rise_cyc = cyc;
        if (lock_ok && !p_lock) lock_rise_cyc = cyc;
        p_up = pump_up; p_dn = pump_dn; p_lock = lock_ok;
    end

    task automatic step(input logic r, input logic v);
        @(negedge clk);
        ref_pulse = r;
        vco_pulse = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    task automatic sample();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int rises0;
        int lfsr;
        repeat (3) @(negedge clk);
        check("R10", "reset pump_up", int'(pump_up), 0);
        check("R10", "reset lock_ok", int'(lock_ok), 0);
        @(negedge clk);
        rst = 0;
        sample();
        check("R10", "release nand_act", int'(nand_act), 0);

        // R9: arming needs two reference edges
        idle(10);
        sample();
        check("R9", "lock before edges", int'(lock_ok), 0);
        step(1, 1); idle(4);
        sample();
        check("R9", "lock after one edge", int'(lock_ok), 0);
        step(1, 1); idle(4);
        sample();
        check("R9", "lock after two edges", int'(lock_ok), 1);

        // R2: reference leads by 5
        step(1, 0); idle(4); step(0, 1); idle(6);
        check("R2", "up width", last_up_w, 6);
        check("R2", "dn width", last_dn_w, 1);

        // R3: oscillator leads by 3
        step(0, 1); idle(2); step(1, 0); idle(6);
        check("R3", "dn width", last_dn_w, 4);
        check("R3", "up width", last_up_w, 1);

        // R4: coincident edges
        step(1, 1); idle(6);
        check("R4", "up width", last_up_w, 1);
        check("R4", "dn width", last_dn_w, 1);

        // R1: reference held high across the cleared pulse
        rises0 = up_rises;
        step(1, 0); step(1, 0); step(1, 1);
        for (int i = 0; i < 5; i++) step(1, 0);
        sample();
        check("R1", "up while level held", int'(pump_up), 0);
        check("R1", "single up pulse", up_rises - rises0, 1);
        idle(6);

        // R5: output gating
        out_en = 1'b0;
        rises0 = up_rises;
        step(1, 0); idle(1);
        sample();
        check("R5", "gated pump_up", int'(pump_up), 0);
        check("R5", "activity kept", int'(nand_act), 1);
        idle(2); step(0, 1); idle(4);
        check("R5", "no up pulse seen", up_rises - rises0, 0);
        out_en = 1'b1;
        idle(4);

        // R7: saturate, then time the decay to lock
        lock_thresh = 6'd20;
        step(1, 0); idle(100);
        sample();
        check("R7", "lock while saturated", int'(lock_ok), 0);
        step(0, 1); idle(80);
        check("R7", "decay cycles", lock_rise_cyc - dn_rise_cyc, 65 - 20);

        // R8: threshold edges
        lock_thresh = 6'd0;
        sample();
        check("R8", "zero threshold", int'(lock_ok), 0);
        lock_thresh = 6'd20;
        sample();
        check("R8", "threshold restored", int'(lock_ok), 1);

        // mixed pattern, compared every cycle
        lfsr = 32'h1ACE;
        for (int i = 0; i < 400; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            out_en = (lfsr[7:5] != 3'd0);
            lock_thresh = 6'(lfsr[13:8]);
            step(lfsr[0] & lfsr[3], lfsr[1] & lfsr[4]);
        end
        idle(10);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule